// File: doc/BRIEF.md
# Four-Channel Pulse-Width Modulator with Register Port

This block produces four independent pulse-width modulated outputs under the control of a small memory-mapped register bank. Each channel has a prescaler that counts input clocks up to a 16-bit divider value. Each time the prescaler completes, an 8-bit phase counter steps forward, so one full output period is the divider times 256 input clocks. The output stays high while the phase counter is below the channel's 8-bit duty value.

Software configures a channel by writing a divider, a duty word, and bits in two control words. The duty word also names which of the four dividers paces the channel, so several channels can share one divider setting. A channel can run normally, be held high through a hold-high bit, or be driven low by clearing its output-enable bit. A write to a divider or duty value acts on the running counter straight away; the current period is not completed first. Register access is single-cycle: a write is captured on the clock edge where the write strobe is high, and read data is valid in the same cycle as the read strobe.

Top module: `pwm_array`

## Requirements
- R1: After reset every register reads as zero, every prescaler and phase counter is zero, and all four outputs are low.
- R2: The control word at byte address 0x00 keeps output-enable for channel n in bit n and hold-high for channel n in bit 8+n. The count-enable word at 0x04 keeps channel n in bit n. The divider of channel n sits at 0x08+4n in bits 15:0. The duty word of channel n sits at 0x18+4n, with the duty count in bits 7:0 and the divider select in bits 9:8. Each register reads back the value written, with all other bits zero, and any other address reads zero.
- R3: With output-enable and count-enable set and hold-high clear, a channel paced by divider value D (D not zero) repeats with a period of D×256 clocks and is high for D×duty clocks of each period.
- R4: Bits 9:8 of a channel's duty word select which channel's divider value paces that channel.
- R5: When output-enable and hold-high are both set, the output is constantly high, whatever the count-enable and duty values.
- R6: When output-enable is clear, the output is low, whatever the hold-high, count-enable and duty values.
- R7: A divider value of zero paces the channel exactly as a divider value of one.
- R8: While count-enable is clear, the channel's prescaler and phase counter are held at zero and its output is low unless hold-high applies; after count-enable is set again, the first high phase lasts the full D×duty clocks.
- R9: A new duty value or divider value acts on the running counter from the clock after the write, without waiting for the end of the period; a prescaler already at or above the new terminal count steps the phase counter on the next clock.
- R10: A duty value of zero keeps a running channel low for the whole period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for all state |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Byte address of the register access |
| wdata_i | input | 32 | Write data |
| wr_en_i | input | 1 | Write strobe, captured on the rising clock edge |
| rd_en_i | input | 1 | Read strobe; read data is zero when low |
| rdata_o | output | 32 | Read data, valid in the cycle of the read strobe |
| pwm_o | output | 4 | Pulse-width modulated outputs, bit n for channel n |

## Verification
The two functions that meet in one cycle are a register write and the running count: a duty or divider update lands on a clock edge in the middle of a period, while the phase counter is above or below the new threshold. The bench provokes this by locking onto a rising edge of the output, waiting a known number of clocks, and then writing a duty value below, or above, the current phase count. It judges the outcome by sampling the pin at the first falling clock edge after the write, where the output has to have dropped or risen already, instead of at the end of the period. Clearing and setting count-enable in mid-period is judged the same way, by the length of the first high phase after the counter restarts.

// File: rtl/pwm_array_pkg.sv
package pwm_array_pkg;

    localparam int unsigned PWM_NCH    = 4;
    localparam int unsigned PWM_DIV_W  = 16;
    localparam int unsigned PWM_DUTY_W = 8;
    localparam int unsigned PWM_DATA_W = 32;
    localparam int unsigned PWM_ADDR_W = 8;

    // byte offsets of the register words
    localparam int unsigned OFS_OUT    = 0;
    localparam int unsigned OFS_CNT    = 4;
    localparam int unsigned OFS_DIV    = 8;
    localparam int unsigned OFS_STRIDE = 4;

    // first hold-high bit inside the control word
    localparam int unsigned BYP_LSB    = 8;

endpackage

// File: rtl/pwm_array_regs.sv
module pwm_array_regs
    import pwm_array_pkg::*;
#(
    parameter int unsigned NCH    = PWM_NCH,
    parameter int unsigned DIV_W  = PWM_DIV_W,
    parameter int unsigned DUTY_W = PWM_DUTY_W,
    parameter int unsigned DATA_W = PWM_DATA_W,
    parameter int unsigned ADDR_W = PWM_ADDR_W,
    parameter int unsigned SEL_W  = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                           clk_i,
    input  logic                           rst_ni,
    input  logic [ADDR_W-1:0]              addr_i,
    input  logic [DATA_W-1:0]              wdata_i,
    input  logic                           wr_en_i,
    input  logic                           rd_en_i,
    output logic [DATA_W-1:0]              rdata_o,
    output logic [NCH-1:0]                 oe_o,
    output logic [NCH-1:0]                 byp_o,
    output logic [NCH-1:0]                 ce_o,
    output logic [NCH-1:0][DIV_W-1:0]      div_o,
    output logic [NCH-1:0][DUTY_W-1:0]     duty_o,
    output logic [NCH-1:0][SEL_W-1:0]      sel_o
);

    localparam int unsigned OFS_DUTY = OFS_DIV + OFS_STRIDE * NCH;

    typedef struct packed {
        logic [NCH-1:0]             oe;
        logic [NCH-1:0]             byp;
        logic [NCH-1:0]             ce;
        logic [NCH-1:0][DIV_W-1:0]  div;
        logic [NCH-1:0][DUTY_W-1:0] duty;
        logic [NCH-1:0][SEL_W-1:0]  sel;
    } rf_t;

    rf_t rf_d, rf_q;

    // bits above the widest field never reach a register
    logic unused_wbits;
    assign unused_wbits = ^wdata_i[DATA_W-1:DIV_W];

    always_comb begin
        rf_d = rf_q;
        if (wr_en_i) begin
            if (addr_i == ADDR_W'(OFS_OUT)) begin
                rf_d.oe  = wdata_i[NCH-1:0];
                rf_d.byp = wdata_i[BYP_LSB +: NCH];
            end
            if (addr_i == ADDR_W'(OFS_CNT)) begin
                rf_d.ce = wdata_i[NCH-1:0];
            end
            for (int n = 0; n < NCH; n++) begin
                if (addr_i == ADDR_W'(OFS_DIV + OFS_STRIDE * n)) begin
                    rf_d.div[n] = wdata_i[DIV_W-1:0];
                end
                if (addr_i == ADDR_W'(OFS_DUTY + OFS_STRIDE * n)) begin
                    rf_d.duty[n] = wdata_i[DUTY_W-1:0];
                    rf_d.sel[n]  = wdata_i[DUTY_W +: SEL_W];
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rf_q <= '0;
        end else begin
            rf_q <= rf_d;
        end
    end

    always_comb begin
        rdata_o = '0;
        if (rd_en_i) begin
            if (addr_i == ADDR_W'(OFS_OUT)) begin
                rdata_o[NCH-1:0]        = rf_q.oe;
                rdata_o[BYP_LSB +: NCH] = rf_q.byp;
            end
            if (addr_i == ADDR_W'(OFS_CNT)) begin
                rdata_o[NCH-1:0] = rf_q.ce;
            end
            for (int n = 0; n < NCH; n++) begin
                if (addr_i == ADDR_W'(OFS_DIV + OFS_STRIDE * n)) begin
                    rdata_o[DIV_W-1:0] = rf_q.div[n];
                end
                if (addr_i == ADDR_W'(OFS_DUTY + OFS_STRIDE * n)) begin
                    rdata_o[DUTY_W-1:0]    = rf_q.duty[n];
                    rdata_o[DUTY_W +: SEL_W] = rf_q.sel[n];
                end
            end
        end
    end

    assign oe_o   = rf_q.oe;
    assign byp_o  = rf_q.byp;
    assign ce_o   = rf_q.ce;
    assign div_o  = rf_q.div;
    assign duty_o = rf_q.duty;
    assign sel_o  = rf_q.sel;

endmodule

// File: rtl/pwm_array_chan.sv
module pwm_array_chan
    import pwm_array_pkg::*;
#(
    parameter int unsigned DIV_W  = PWM_DIV_W,
    parameter int unsigned DUTY_W = PWM_DUTY_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              ce_i,
    input  logic              oe_i,
    input  logic              byp_i,
    input  logic [DUTY_W-1:0] duty_i,
    input  logic [DIV_W-1:0]  div_i,
    output logic              pwm_o,
    output logic [DUTY_W-1:0] cnt_o,
    output logic [DIV_W-1:0]  pre_o
);

    typedef struct packed {
        logic [DIV_W-1:0]  pre;
        logic [DUTY_W-1:0] cnt;
    } st_t;

    st_t              st_d, st_q;
    logic [DIV_W-1:0] term;

    // terminal prescaler count; a zero divider behaves like one
    always_comb begin
        term = (div_i == '0) ? '0 : div_i - 1'b1;
    end

    always_comb begin
        st_d = st_q;
        if (!ce_i) begin
            st_d = '0;
        end else if (st_q.pre >= term) begin
            st_d.pre = '0;
            st_d.cnt = st_q.cnt + 1'b1;
        end else begin
            st_d.pre = st_q.pre + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pwm_o = oe_i & (byp_i | (ce_i & (st_q.cnt < duty_i)));
    assign cnt_o = st_q.cnt;
    assign pre_o = st_q.pre;

endmodule

// File: rtl/pwm_array.sv
module pwm_array
    import pwm_array_pkg::*;
#(
    parameter int unsigned NCH    = PWM_NCH,
    parameter int unsigned DIV_W  = PWM_DIV_W,
    parameter int unsigned DUTY_W = PWM_DUTY_W,
    parameter int unsigned DATA_W = PWM_DATA_W,
    parameter int unsigned ADDR_W = PWM_ADDR_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic [NCH-1:0]    pwm_o
);

    localparam int unsigned SEL_W = (NCH > 1) ? $clog2(NCH) : 1;

    logic [NCH-1:0]             oe_w;
    logic [NCH-1:0]             byp_w;
    logic [NCH-1:0]             ce_w;
    logic [NCH-1:0][DIV_W-1:0]  div_w;
    logic [NCH-1:0][DUTY_W-1:0] duty_w;
    logic [NCH-1:0][SEL_W-1:0]  sel_w;
    logic [NCH-1:0][DIV_W-1:0]  div_mux;
    logic [NCH-1:0][DUTY_W-1:0] cnt_w;
    logic [NCH-1:0][DIV_W-1:0]  pre_w;

    pwm_array_regs #(
        .NCH    (NCH),
        .DIV_W  (DIV_W),
        .DUTY_W (DUTY_W),
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .SEL_W  (SEL_W)
    ) u_regs (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .addr_i  (addr_i),
        .wdata_i (wdata_i),
        .wr_en_i (wr_en_i),
        .rd_en_i (rd_en_i),
        .rdata_o (rdata_o),
        .oe_o    (oe_w),
        .byp_o   (byp_w),
        .ce_o    (ce_w),
        .div_o   (div_w),
        .duty_o  (duty_w),
        .sel_o   (sel_w)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        assign div_mux[g] = div_w[sel_w[g]];

        pwm_array_chan #(
            .DIV_W  (DIV_W),
            .DUTY_W (DUTY_W)
        ) u_chan (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .ce_i   (ce_w[g]),
            .oe_i   (oe_w[g]),
            .byp_i  (byp_w[g]),
            .duty_i (duty_w[g]),
            .div_i  (div_mux[g]),
            .pwm_o  (pwm_o[g]),
            .cnt_o  (cnt_w[g]),
            .pre_o  (pre_w[g])
        );
    end

endmodule

// File: rtl/pwm_array_chk.sv
module pwm_array_chk
    import pwm_array_pkg::*;
#(
    parameter int unsigned NCH    = PWM_NCH,
    parameter int unsigned DIV_W  = PWM_DIV_W,
    parameter int unsigned DUTY_W = PWM_DUTY_W,
    parameter int unsigned ADDR_W = PWM_ADDR_W
) (
    input logic                       clk_i,
    input logic                       rst_ni,
    input logic                       wr_en_i,
    input logic [ADDR_W-1:0]          addr_i,
    input logic [NCH-1:0]             wd_lo_i,
    input logic [NCH-1:0]             oe_i,
    input logic [NCH-1:0]             byp_i,
    input logic [NCH-1:0]             ce_i,
    input logic [NCH-1:0][DUTY_W-1:0] duty_i,
    input logic [NCH-1:0][DIV_W-1:0]  div_i,
    input logic [NCH-1:0][DUTY_W-1:0] cnt_i,
    input logic [NCH-1:0][DIV_W-1:0]  pre_i,
    input logic [NCH-1:0]             pwm_i
);

    // R2
    ce_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && addr_i == ADDR_W'(OFS_CNT)) |=> (ce_i == $past(wd_lo_i)));

    for (genvar g = 0; g < NCH; g++) begin : g_chk
        // R8
        ce_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !ce_i[g] |=> (cnt_i[g] == '0 && pre_i[g] == '0));

        // R3
        cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (cnt_i[g] != $past(cnt_i[g])) |->
            (cnt_i[g] == DUTY_W'($past(cnt_i[g]) + 1'b1) || cnt_i[g] == '0));

        // R9
        pre_over_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (ce_i[g] && div_i[g] != '0 && pre_i[g] >= div_i[g]) |=> (pre_i[g] == '0));

        // R7
        div_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (ce_i[g] && div_i[g] == '0) |=> (pre_i[g] == '0));

        // R6
        oe_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !oe_i[g] |-> !pwm_i[g]);

        // R5
        hold_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (oe_i[g] && byp_i[g]) |-> pwm_i[g]);

        // R10
        zero_duty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (!byp_i[g] && duty_i[g] == '0) |-> !pwm_i[g]);
    end

endmodule

bind pwm_array pwm_array_chk #(
    .NCH    (NCH),
    .DIV_W  (DIV_W),
    .DUTY_W (DUTY_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wd_lo_i (wdata_i[NCH-1:0]),
    .oe_i    (oe_w),
    .byp_i   (byp_w),
    .ce_i    (ce_w),
    .duty_i  (duty_w),
    .div_i   (div_mux),
    .cnt_i   (cnt_w),
    .pre_i   (pre_w),
    .pwm_i   (pwm_o)
);

// File: tb/sim_pwm_array.sv
module sim_pwm_array;

    localparam int NV      = 7;
    localparam int TIMEOUT = 6000;

    // each entry: {channel, divider select, divider value, duty}
    localparam logic [31:0] VEC [NV] = '{
        {8'd0, 8'd0, 8'd2, 8'd64},
        {8'd1, 8'd1, 8'd1, 8'd200},
        {8'd2, 8'd2, 8'd0, 8'd10},
        {8'd3, 8'd3, 8'd3, 8'd128},
        {8'd3, 8'd1, 8'd2, 8'd50},
        {8'd0, 8'd0, 8'd1, 8'd255},
        {8'd1, 8'd2, 8'd4, 8'd1}
    };

    logic        clk;
    logic        rst_n;
    logic [7:0]  addr;
    logic [31:0] wdata;
    logic        wr_en;
    logic        rd_en;
    logic [31:0] rdata;
    logic [3:0]  pwm;

    int nchk  = 0;
    int nfail = 0;

    pwm_array u0 (
        .clk_i   (clk),
        .rst_ni  (rst_n),
        .addr_i  (addr),
        .wdata_i (wdata),
        .wr_en_i (wr_en),
        .rd_en_i (rd_en),
        .rdata_o (rdata),
        .pwm_o   (pwm)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    task automatic check(input string req, input longint act, input longint exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr  = a;
        wdata = d;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        addr  = a;
        rd_en = 1'b1;
        #1;
        d     = rdata;
        rd_en = 1'b0;
    endtask

    task automatic measure(input int ch, output int hi, output int per);
        int t = 0;
        int h = 0;
        int l = 0;
        hi  = -1;
        per = -1;
        while (pwm[ch] && t < TIMEOUT) begin @(negedge clk); t++; end
        while (!pwm[ch] && t < TIMEOUT) begin @(negedge clk); t++; end
        while (pwm[ch] && t < TIMEOUT) begin h++; @(negedge clk); t++; end
        while (!pwm[ch] && t < TIMEOUT) begin l++; @(negedge clk); t++; end
        if (t < TIMEOUT) begin
            hi  = h;
            per = h + l;
        end
    endtask

    task automatic count_level(input int ch, input logic lvl, input int n, output int cnt);
        cnt = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (pwm[ch] == lvl) cnt++;
        end
    endtask

    task automatic run_len(input int ch, output int cnt);
        cnt = 0;
        while (pwm[ch] && cnt < TIMEOUT) begin cnt++; @(negedge clk); end
    endtask

    task automatic clear_all();
        wr(8'h00, 32'h0);
        wr(8'h04, 32'h0);
        for (int n = 0; n < 4; n++) begin
            wr(8'(8 + 4 * n), 32'h0);
            wr(8'(8'h18 + 4 * n), 32'h0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [31:0] acc;
        int hi, per, c;
        rst_n = 1'b0;
        addr  = '0;
        wdata = '0;
        wr_en = 1'b0;
        rd_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state of all registers and pins
        acc = '0;
        for (int n = 0; n < 10; n++) begin
            rd(8'(4 * n), d);
            acc |= d;
        end
        check("R1 registers", acc, 0);
        check("R1 outputs", pwm, 0);

        // R2: read back with field masks
        wr(8'h00, 32'hFFFF_FFFF);
        rd(8'h00, d); check("R2 control", d, 32'h0000_0F0F);
        wr(8'h04, 32'hFFFF_FFFF);
        rd(8'h04, d); check("R2 count enable", d, 32'h0000_000F);
        wr(8'h10, 32'hFFFF_ABCD);
        rd(8'h10, d); check("R2 divider", d, 32'h0000_ABCD);
        wr(8'h24, 32'hFFFF_FFFF);
        rd(8'h24, d); check("R2 duty", d, 32'h0000_03FF);
        rd(8'h40, d); check("R2 unmapped", d, 0);
        rd(8'h02, d); check("R2 misaligned", d, 0);
        clear_all();

        // R3 / R4 / R7: period and high time from the vector table
        for (int i = 0; i < NV; i++) begin
            int ch, sel, dv, dt, eff;
            string tag;
            ch  = int'(VEC[i][31:24]);
            sel = int'(VEC[i][23:16]);
            dv  = int'(VEC[i][15:8]);
            dt  = int'(VEC[i][7:0]);
            eff = (dv == 0) ? 1 : dv;
            tag = (dv == 0) ? "R7" : (sel != ch) ? "R4" : "R3";
            wr(8'(8 + 4 * sel), 32'(dv));
            wr(8'(8'h18 + 4 * ch), 32'((sel << 8) | dt));
            wr(8'h04, 32'(1 << ch));
            wr(8'h00, 32'(1 << ch));
            measure(ch, hi, per);
            check({tag, " high time"}, hi, eff * dt);
            check({tag, " period"}, per, eff * 256);
            wr(8'h00, 32'h0);
            wr(8'h04, 32'h0);
        end
        clear_all();

        // R5: hold-high with counting off and duty zero
        wr(8'h00, 32'h0000_0202);
        count_level(1, 1'b1, 300, c);
        check("R5 hold high", c, 300);
        clear_all();

        // R6: output-enable clear masks hold-high and a running counter
        wr(8'h0C + 8'h04, 32'h1);
        wr(8'h20, 32'h0000_02FF);
        wr(8'h04, 32'hF);
        wr(8'h00, 32'h0000_0400);
        count_level(2, 1'b0, 600, c);
        check("R6 disabled low", c, 600);
        clear_all();

        // R10: zero duty on a running channel
        wr(8'h08, 32'h1);
        wr(8'h04, 32'h1);
        wr(8'h00, 32'h1);
        count_level(0, 1'b0, 600, c);
        check("R10 zero duty", c, 600);
        clear_all();

        // R8: clearing count-enable mid-period, then restarting
        wr(8'h08, 32'h1);
        wr(8'h18, 32'd100);
        wr(8'h04, 32'h1);
        wr(8'h00, 32'h1);
        repeat (37) @(negedge clk);
        wr(8'h04, 32'h0);
        check("R8 low when stopped", pwm[0], 0);
        count_level(0, 1'b0, 50, c);
        check("R8 stays low", c, 50);
        wr(8'h04, 32'h1);
        run_len(0, c);
        check("R8 full first high", c, 100);
        clear_all();

        // R9: duty changes while the counter runs
        wr(8'h08, 32'h1);
        wr(8'h18, 32'd200);
        wr(8'h04, 32'h1);
        wr(8'h00, 32'h1);
        c = 0;
        while (pwm[0] && c < TIMEOUT) begin @(negedge clk); c++; end
        while (!pwm[0] && c < TIMEOUT) begin @(negedge clk); c++; end
        repeat (50) @(negedge clk);
        wr(8'h18, 32'd20);
        check("R9 duty lowered drops at once", pwm[0], 0);
        repeat (30) @(negedge clk);
        wr(8'h18, 32'd255);
        check("R9 duty raised rises at once", pwm[0], 1);
        clear_all();

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule